// File: doc/BRIEF.md
# Two-Cycle Multi-Mode Byte Multiplier

This block is the multiply unit of a small 8-bit CPU datapath. It takes two byte operands, a 3-bit operation code and a one-cycle start pulse. It returns the 16-bit product split into a high byte and a low byte. It also returns a zero flag, a carry flag and a one-cycle done pulse. The same hardware serves six operations: unsigned times unsigned, signed times signed, and signed times unsigned, each in an integer form and a fractional form. The fractional form is the integer product shifted one place to the left.

Each operand is extended to a 9-bit two's-complement value according to the operation code, so every mode becomes one signed product. The second operand is cut into nibble slices. In the first cycle the slice partial products are formed and registered. In the second cycle they are summed, shifted if the mode is fractional, and the flags are derived. Result, flags and done are all registered. The result and flags stay unchanged until the next operation completes. The surrounding core handles decoding, operand fetch and register write-back.

Top module: `mul_byte_unit`

## Requirements
- R1: A start pulse accepted in cycle c makes done_o high in cycle c+2, and done_o is never high without such a start two cycles earlier.
- R2: done_o is high for exactly one cycle per accepted operation. A new start may be accepted in the cycle in which done_o is high.
- R3: A start_i that arrives in the cycle after an accepted start, while the unit is busy, is ignored. It produces no extra done pulse and leaves the result of the running operation unchanged, and the operands used are those presented with the accepted start.
- R4: With op_mode_i = 3'b000, the result {prod_hi_o, prod_lo_o} is the unsigned product of opa_i and opb_i.
- R5: With op_mode_i = 3'b001, both operands are two's-complement and the result is their signed product, modulo 2^16.
- R6: With op_mode_i = 3'b010, opa_i is two's-complement, opb_i is unsigned, and the result is their product, modulo 2^16.
- R7: op_mode_i bit 2 selects the fractional form. Codes 3'b100, 3'b101 and 3'b110 return the product of codes 000, 001 and 010, shifted left by one bit, with bit 0 of the result equal to 0.
- R8: carry_o equals bit 15 of the integer product, taken before any fractional shift.
- R9: zero_o is 1 exactly when the final 16-bit result is all zeros.
- R10: Operation codes 3'b011 and 3'b111 behave as 3'b000 and 3'b100, unsigned.
- R11: After reset the result, zero_o, carry_o and done_o are 0. Result and flags hold their last values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| op_mode_i | input | 3 | Bit 2 selects fractional; bits 1:0 are 00 unsigned, 01 signed, 10 signed-by-unsigned, 11 unsigned |
| opa_i | input | 8 | First operand (the signed one in signed-by-unsigned) |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| zero_o | output | 1 | Result is zero |
| carry_o | output | 1 | Bit 15 of the integer product |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
A wrong extension of an operand shows at the ports only when that operand's top bit is set. For this reason the vectors include negative and 0x80 operands in every signedness mode, and the wrong bits appear in the high byte on the next done pulse. A fault in the busy state shows either as a second done pulse or as a result computed from the late operands, two cycles after the extra start. A fault in the fractional path or the flags shows in the same cycle as done, in bit 0 of the result or in carry_o compared with the unshifted product.

// File: rtl/mul_byte_pkg.sv
package mul_byte_pkg;
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_UU2 = 2'b11
  } sign_mode_e;

  function automatic logic a_is_signed(input sign_mode_e m);
    return (m == SGN_SS) || (m == SGN_SU);
  endfunction

  function automatic logic b_is_signed(input sign_mode_e m);
    return (m == SGN_SS);
  endfunction
endpackage

// File: rtl/mul_operand_ext.sv
module mul_operand_ext
  import mul_byte_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [2:0]             op_mode_i,
  input  logic [OP_W-1:0]        opa_i,
  input  logic [OP_W-1:0]        opb_i,
  output logic signed [OP_W:0]   a_ext_o,
  output logic signed [OP_W:0]   b_ext_o,
  output logic                   frac_o
);
  sign_mode_e sgn;

  always_comb begin
    sgn     = sign_mode_e'(op_mode_i[1:0]);
    a_ext_o = {a_is_signed(sgn) & opa_i[OP_W-1], opa_i};
    b_ext_o = {b_is_signed(sgn) & opb_i[OP_W-1], opb_i};
    frac_o  = op_mode_i[2];
  end
endmodule

// File: rtl/mul_pp_stage.sv
module mul_pp_stage #(
  parameter int OP_W    = 8,
  parameter int SLICE_W = 4,
  localparam int NSLICE = OP_W / SLICE_W,
  localparam int PP_W   = OP_W + SLICE_W + 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic signed [OP_W:0]         a_ext_i,
  input  logic signed [OP_W:0]         b_ext_i,
  input  logic                         frac_i,
  output logic [NSLICE-1:0][PP_W-1:0]  pp_o,
  output logic                         frac_o,
  output logic                         valid_o
);
  logic [NSLICE-1:0][PP_W-1:0] pp_d;

  for (genvar j = 0; j < NSLICE; j++) begin : g_slice
    logic signed [SLICE_W:0] bs;
    if (j < NSLICE - 1) begin : g_low
      assign bs = $signed({1'b0, b_ext_i[j*SLICE_W +: SLICE_W]});
    end else begin : g_top
      assign bs = $signed(b_ext_i[OP_W:(NSLICE-1)*SLICE_W]);
    end
    assign pp_d[j] = $signed(PP_W'(a_ext_i)) * $signed(PP_W'(bs));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_o    <= '0;
      frac_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        pp_o   <= pp_d;
        frac_o <= frac_i;
      end
    end
  end
endmodule

// File: rtl/mul_finish.sv
module mul_finish #(
  parameter int OP_W    = 8,
  parameter int SLICE_W = 4,
  localparam int NSLICE = OP_W / SLICE_W,
  localparam int PP_W   = OP_W + SLICE_W + 2,
  localparam int RES_W  = 2 * OP_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         frac_i,
  input  logic [NSLICE-1:0][PP_W-1:0]  pp_i,
  output logic [OP_W-1:0]              hi_o,
  output logic [OP_W-1:0]              lo_o,
  output logic                         zero_o,
  output logic                         carry_o,
  output logic                         done_o
);
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] res;
  logic             frac_q;

  always_comb begin
    acc = '0;
    for (int j = 0; j < NSLICE; j++) begin
      acc = acc + RES_W'($signed(RES_W'($signed(pp_i[j]))) <<< (j * SLICE_W));
    end
    res = frac_i ? {acc[RES_W-2:0], 1'b0} : acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o    <= '0;
      lo_o    <= '0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
      done_o  <= 1'b0;
      frac_q  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        {hi_o, lo_o} <= res;
        zero_o       <= (res == '0);
        carry_o      <= acc[RES_W-1];  // pre-shift
        frac_q       <= frac_i;
      end
    end
  end

  // R7: fractional result has a cleared lsb
  p_frac_lsb_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && frac_q) |-> (lo_o[0] == 1'b0));

  // R8: integer result exposes its own msb as carry
  p_carry_int_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !frac_q) |-> (carry_o == hi_o[OP_W-1]));

  // R9: zero flag agrees with the presented result
  p_zero_flag_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == ({hi_o, lo_o} == '0)));
endmodule

// File: rtl/mul_byte_unit.sv
module mul_byte_unit #(
  parameter int OP_W    = 8,
  parameter int SLICE_W = 4,
  localparam int NSLICE = OP_W / SLICE_W,
  localparam int PP_W   = OP_W + SLICE_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_mode_i,
  input  logic [OP_W-1:0] opa_i,
  input  logic [OP_W-1:0] opb_i,
  output logic [OP_W-1:0] prod_hi_o,
  output logic [OP_W-1:0] prod_lo_o,
  output logic            zero_o,
  output logic            carry_o,
  output logic            done_o
);
  logic signed [OP_W:0]        a_ext, b_ext;
  logic                        frac_c, frac_s;
  logic                        busy, load;
  logic [NSLICE-1:0][PP_W-1:0] pp;

  assign load = start_i && !busy;  // late start dropped

  mul_operand_ext #(.OP_W(OP_W)) u_ext (
    .op_mode_i (op_mode_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .a_ext_o   (a_ext),
    .b_ext_o   (b_ext),
    .frac_o    (frac_c)
  );

  mul_pp_stage #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_pp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .a_ext_i (a_ext),
    .b_ext_i (b_ext),
    .frac_i  (frac_c),
    .pp_o    (pp),
    .frac_o  (frac_s),
    .valid_o (busy)
  );

  mul_finish #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_fin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (busy),
    .frac_i  (frac_s),
    .pp_i    (pp),
    .hi_o    (prod_hi_o),
    .lo_o    (prod_lo_o),
    .zero_o  (zero_o),
    .carry_o (carry_o),
    .done_o  (done_o)
  );

  // R1: done only two cycles after a start
  p_done_latency_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));

  // R2: single-cycle done pulse
  p_done_pulse_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3: busy never lasts beyond one cycle
  p_busy_once_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !busy);

  // R11: outputs hold between completions
  p_hold_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable({prod_hi_o, prod_lo_o}) && $stable(zero_o) && $stable(carry_o)));
endmodule

// File: tb/mul_byte_unit_bench.sv
module mul_byte_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] hi, lo;
  logic       zero, carry, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mul_byte_unit u_mul_byte_unit (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .op_mode_i (mode),
    .opa_i (a), .opb_i (b), .prod_hi_o (hi), .prod_lo_o (lo),
    .zero_o (zero), .carry_o (carry), .done_o (done)
  );

  // {mode, a, b}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'hFF, 8'hFF}, {3'd0, 8'h00, 8'h5A}, {3'd0, 8'h12, 8'h34}, {3'd0, 8'h80, 8'h02},
    {3'd1, 8'h80, 8'h80}, {3'd1, 8'hFF, 8'hFF}, {3'd1, 8'h80, 8'h7F}, {3'd1, 8'h7F, 8'h7F},
    {3'd2, 8'hFF, 8'hFF}, {3'd2, 8'h80, 8'hFF}, {3'd2, 8'h7F, 8'h80}, {3'd2, 8'hC3, 8'h00},
    {3'd4, 8'hFF, 8'hFF}, {3'd4, 8'h80, 8'h80}, {3'd5, 8'h80, 8'h80}, {3'd5, 8'hC0, 8'h40},
    {3'd6, 8'h80, 8'hFF}, {3'd6, 8'h40, 8'h40}, {3'd3, 8'hF0, 8'h88}, {3'd7, 8'h81, 8'hC1}
  };

  function automatic logic [17:0] model(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y);
    int xv, yv, p;
    logic [15:0] ip, r;
    xv = ((m[1:0] == 2'b01) || (m[1:0] == 2'b10)) ? int'($signed(x)) : int'(x);
    yv = (m[1:0] == 2'b01) ? int'($signed(y)) : int'(y);
    p  = xv * yv;
    ip = p[15:0];
    r  = m[2] ? {ip[14:0], 1'b0} : ip;
    return {r == 16'h0, ip[15], r};
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd7: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_result(input string tag, input logic [17:0] e);
    chk({hi, lo} == e[15:0], tag, {hi, lo}, e[15:0]);
    chk(carry == e[16], {tag, "/R8"}, carry, e[16]);
    chk(zero == e[17], {tag, "/R9"}, zero, e[17]);
  endtask

  // inputs change on the falling edge; start sampled on the next rising edge
  task automatic run_op(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y, input string tag);
    @(negedge clk);
    mode = m; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R1 early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R1 latency", done, 1);
    check_result(tag, model(m, x, y));
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [17:0] e1, e2;
    repeat (3) @(negedge clk);
    chk({hi, lo} == 16'h0, "R11 reset result", {hi, lo}, 0);
    chk({zero, carry, done} == 3'b000, "R11 reset flags", {zero, carry, done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], tag_of(VEC[i][18:16]));
      @(negedge clk);
      chk(done == 1'b0, "R2 pulse width", done, 0);
    end

    // hand-derived corner values
    run_op(3'd4, 8'hFF, 8'hFF, "R7 frac unsigned max");
    chk({hi, lo} == 16'hFC02 && carry, "R8 carry before shift", {carry, hi, lo}, 17'h1FC02);
    run_op(3'd5, 8'h80, 8'h80, "R7 frac signed min");
    chk({hi, lo} == 16'h8000 && !carry, "R8 shift-out not carry", {carry, hi, lo}, 17'h08000);
    run_op(3'd2, 8'hFF, 8'hFF, "R6 su -1*255");
    chk({hi, lo} == 16'hFF01, "R6 value", {hi, lo}, 16'hFF01);
    run_op(3'd1, 8'h00, 8'h80, "R9 zero");
    chk(zero == 1'b1, "R9 zero set", zero, 1);

    // R3: second start while busy, with different operands
    e1 = model(3'd0, 8'h11, 8'h22);
    @(negedge clk);
    mode = 3'd0; a = 8'h11; b = 8'h22; start = 1'b1;
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; mode = 3'd1;  // start stays high: busy cycle
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R3 first done", done, 1);
    check_result("R3 operands of accepted start", e1);
    @(negedge clk);
    chk(done == 1'b0, "R3 no extra done", done, 0);
    check_result("R3 result unchanged", e1);
    @(negedge clk);
    chk(done == 1'b0, "R3 still no done", done, 0);

    // R2: back-to-back, new start in the done cycle
    e1 = model(3'd1, 8'h9C, 8'h37);
    e2 = model(3'd6, 8'hA5, 8'h5A);
    @(negedge clk);
    mode = 3'd1; a = 8'h9C; b = 8'h37; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R2 first of pair", done, 1);
    check_result("R2 first result", e1);
    mode = 3'd6; a = 8'hA5; b = 8'h5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R2 gap", done, 0);
    check_result("R11 hold during op", e1);
    @(negedge clk);
    chk(done == 1'b1, "R2 second of pair", done, 1);
    check_result("R2 second result", e2);

    // R11: operand changes without start leave outputs alone
    @(negedge clk);
    a = 8'h00; b = 8'h00; mode = 3'd0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 no done", done, 0);
    check_result("R11 hold", e2);

    // R11: reset clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk({hi, lo, zero, carry, done} == 19'h0, "R11 reset again", {hi, lo, zero, carry, done}, 0);
    rst_n = 1'b1;
    run_op(3'd7, 8'h03, 8'h05, "R10 code 7");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule